// File: doc/BRIEF.md
# Lane-Partitioned Vector Shift and Rotate Unit

This block performs shifts and rotates on a 128-bit vector operand. In the lane modes the operand is split into four 32-bit words or eight 16-bit halfwords. Each lane is moved by its own amount, which comes from the same lane of a second operand, so one operation can shift every lane by a different distance. Left shifts, logical right shifts and rotates all go through a single rotator per lane. A mask then clears the bits that wrapped around, or clears none of them for a rotate. Two further modes rotate the whole 128-bit vector, either by a bit count or by a whole number of bytes.

Operations arrive on a valid/ready input stream: operand A, operand B and a 3-bit operation code. Results leave on a valid/ready output stream from a single result register. The input side is ready whenever that register is empty or is being drained in the same cycle. A stalled result is held unchanged until the consumer accepts it, and a new operation can be accepted in every cycle in which the consumer takes the previous result.

Top module: `vsr_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: Operation code 000 (word shift left): each 32-bit lane of A is shifted left by bits [5:0] of the matching lane of B, filling with zeros. An amount from 32 to 63 gives a zero lane, and bits [31:6] of the amount are ignored.
- R3: Operation code 001 (word logical shift right): each 32-bit lane of A is shifted right by bits [5:0] of the matching B lane, filling with zeros. An amount of 32 or more gives a zero lane.
- R4: Operation code 010 (word rotate): each 32-bit lane of A is rotated toward the most significant bit by bits [4:0] of the matching B lane.
- R5: Operation codes 100 and 101 (halfword shift left and halfword logical shift right): each 16-bit lane of A is shifted by bits [4:0] of the matching B lane, filling with zeros. An amount of 16 to 31 gives a zero lane.
- R6: Operation code 110 (halfword rotate): each 16-bit lane of A is rotated toward the most significant bit by bits [3:0] of the matching B lane.
- R7: Operation code 011 (vector bit rotate): all 128 bits of A are rotated toward the most significant bit by B[102:96], which is the amount modulo 128 taken from lane 0 of B.
- R8: Operation code 111 (vector byte rotate): all 128 bits of A are rotated toward the most significant bit by 8 times B[99:96], which is the byte count modulo 16 taken from lane 0 of B.
- R9: Lane 0 is the most significant lane in every mode (word lane i is bits [127-32i:96-32i], halfword lane i is bits [127-16i:112-16i]). Each result lane depends only on the same lane of A and of B.
- R10: An operation accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high right after that edge. out_valid never rises without an accepted operation.
- R11: While out_valid is 1 and out_ready is 0, out_valid and out_data stay unchanged and in_ready is 0. When out_ready is 1, a new operation is accepted in the same cycle as the old result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation is valid |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Operation code |
| in_a | input | 128 | Operand moved by the operation |
| in_b | input | 128 | Per-lane shift amounts (lane 0 for vector modes) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, 32-bit words and 16-bit halfwords. With these values it can reach amounts of exactly the lane width, amounts with the ignored upper bits set, and vector rotates that wrap modulo 128 and modulo 16 bytes. Directed operands put different amounts in neighbouring lanes to show that lanes are independent and correctly ordered. A random phase with a throttled consumer covers stalls, back-to-back acceptance and every operation code.

// File: rtl/vsr_pkg.sv
package vsr_pkg;

  // bit 2 selects halfword lanes, bits 1:0 select the kind of move
  typedef enum logic [2:0] {
    OP_SHL_W     = 3'b000,
    OP_SHR_W     = 3'b001,
    OP_ROT_W     = 3'b010,
    OP_ROT_VBIT  = 3'b011,
    OP_SHL_H     = 3'b100,
    OP_SHR_H     = 3'b101,
    OP_ROT_H     = 3'b110,
    OP_ROT_VBYTE = 3'b111
  } vsr_op_e;

  typedef enum logic [1:0] {
    K_SHL = 2'b00,
    K_SHR = 2'b01,
    K_ROT = 2'b10,
    K_VEC = 2'b11
  } vsr_kind_e;

endpackage

// File: rtl/vsr_rotl.sv
module vsr_rotl #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stg [0:AW];

  assign stg[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][W-1-SH:0], stg[s][W-1:W-SH]} : stg[s];
  end

  assign dout = stg[AW];

endmodule

// File: rtl/vsr_lane_unit.sv
module vsr_lane_unit
  import vsr_pkg::*;
#(
  parameter int LW = 32
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  vsr_kind_e     kind,
  output logic [LW-1:0] y
);

  localparam int NW = $clog2(LW);

  logic [NW:0]   amt;
  logic          over;
  logic [NW-1:0] n;
  logic [NW-1:0] rot_n;
  logic [LW-1:0] rotated;
  logic [LW-1:0] mask;
  logic          unused_hi;

  assign amt       = b[NW:0];
  assign over      = amt[NW];
  assign n         = amt[NW-1:0];
  assign unused_hi = ^b[LW-1:NW+1];

  // right moves reuse the left rotator with the complementary distance
  always_comb begin
    if (kind == K_SHR) rot_n = {NW{1'b0}} - n;
    else               rot_n = n;
  end

  vsr_rotl #(.W(LW), .AW(NW)) i_rot (
    .din  (a),
    .amt  (rot_n),
    .dout (rotated)
  );

  always_comb begin
    case (kind)
      K_SHL:   mask = {LW{1'b1}} << n;
      K_SHR:   mask = {LW{1'b1}} >> n;
      default: mask = {LW{1'b1}};
    endcase
    if (over && (kind == K_SHL || kind == K_SHR)) mask = '0;
  end

  assign y = rotated & mask;

endmodule

// File: rtl/vsr_lane_array.sv
module vsr_lane_array
  import vsr_pkg::*;
#(
  parameter int VW = 128,
  parameter int LW = 32
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  vsr_kind_e     kind,
  output logic [VW-1:0] y
);

  localparam int NL = VW / LW;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int HI = VW - 1 - i * LW;
    vsr_lane_unit #(.LW(LW)) i_lane (
      .a    (a[HI -: LW]),
      .b    (b[HI -: LW]),
      .kind (kind),
      .y    (y[HI -: LW])
    );
  end

endmodule

// File: rtl/vsr_vec_rot.sv
module vsr_vec_rot #(
  parameter int VW = 128,
  parameter int SW = 32
) (
  input  logic [VW-1:0] a,
  input  logic [SW-1:0] src,
  input  logic          byte_mode,
  output logic [VW-1:0] y
);

  localparam int AW = $clog2(VW);
  localparam int BW = $clog2(VW / 8);

  logic [AW-1:0] amt;
  logic          unused_src;

  assign unused_src = ^src[SW-1:AW];
  assign amt = byte_mode ? {src[BW-1:0], 3'b000} : src[AW-1:0];

  vsr_rotl #(.W(VW), .AW(AW)) i_rot (
    .din  (a),
    .amt  (amt),
    .dout (y)
  );

endmodule

// File: rtl/vsr_unit.sv
module vsr_unit
  import vsr_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);

  vsr_kind_e        kind;
  logic             half_sel;
  logic             accept;
  logic [VEC_W-1:0] y_word;
  logic [VEC_W-1:0] y_half;
  logic [VEC_W-1:0] y_vec;
  logic [VEC_W-1:0] nxt;

  assign kind     = vsr_kind_e'(in_op[1:0]);
  assign half_sel = in_op[2];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  vsr_lane_array #(.VW(VEC_W), .LW(WORD_W)) i_words (
    .a (in_a), .b (in_b), .kind (kind), .y (y_word)
  );

  vsr_lane_array #(.VW(VEC_W), .LW(HALF_W)) i_halves (
    .a (in_a), .b (in_b), .kind (kind), .y (y_half)
  );

  vsr_vec_rot #(.VW(VEC_W), .SW(WORD_W)) i_vec (
    .a         (in_a),
    .src       (in_b[VEC_W-1 -: WORD_W]),
    .byte_mode (half_sel),
    .y         (y_vec)
  );

  always_comb begin
    if (kind == K_VEC) nxt = y_vec;
    else if (half_sel) nxt = y_half;
    else               nxt = y_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   out_data  <= nxt;
    end
  end

endmodule

// File: rtl/vsr_unit_chk.sv
module vsr_unit_chk
  import vsr_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int WORD_W = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [VEC_W-1:0] in_a,
  input logic [VEC_W-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data
);

  localparam int VA = $clog2(VEC_W);

  logic take;
  assign take = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid); // R10

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R11

  AST_WORD_SHL_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SHL_W && in_b[VEC_W-WORD_W+5]
    |=> out_data[VEC_W-1 -: WORD_W] == '0); // R2

  AST_WORD_SHR_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SHR_W && in_b[VEC_W-WORD_W+5]
    |=> out_data[VEC_W-1 -: WORD_W] == '0); // R3

  AST_HALF_SHR_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_SHR_H && in_b[VEC_W-HALF_W+4]
    |=> out_data[VEC_W-1 -: HALF_W] == '0); // R5

  AST_VROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == OP_ROT_VBIT && in_b[VEC_W-WORD_W +: VA] == '0
    |=> out_data == $past(in_a)); // R7

endmodule

bind vsr_unit vsr_unit_chk #(
  .VEC_W(VEC_W), .WORD_W(WORD_W), .HALF_W(HALF_W)
) i_vsr_unit_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_vsr_unit.sv
`timescale 1ns/1ps
module test_vsr_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  int           n_checks = 0;
  int           n_fail = 0;
  bit           bp_en = 1'b0;
  bit           rdy_manual = 1'b1;
  bit           done = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  vsr_unit i_vsr_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_a (in_a), .in_b (in_b), .out_valid (out_valid),
    .out_ready (out_ready), .out_data (out_data)
  );

  function automatic logic [127:0] ref_calc(logic [2:0] op, logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    r = '0;
    if (op[1:0] == 2'b11) begin
      int n;
      if (op[2]) n = int'(b[99:96]) * 8;
      else       n = int'(b[102:96]);
      r = (a << n) | (a >> (128 - n));
    end else if (!op[2]) begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] x, s, y;
        int k;
        x = a[127-32*i -: 32];
        s = b[127-32*i -: 32];
        case (op[1:0])
          2'b00:   begin k = int'(s[5:0]); y = x << k; end
          2'b01:   begin k = int'(s[5:0]); y = x >> k; end
          default: begin k = int'(s[4:0]); y = (x << k) | (x >> (32 - k)); end
        endcase
        r[127-32*i -: 32] = y;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic [15:0] x, s, y;
        int k;
        x = a[127-16*i -: 16];
        s = b[127-16*i -: 16];
        case (op[1:0])
          2'b00:   begin k = int'(s[4:0]); y = x << k; end
          2'b01:   begin k = int'(s[4:0]); y = x >> k; end
          default: begin k = int'(s[3:0]); y = (x << k) | (x >> (16 - k)); end
        endcase
        r[127-16*i -: 16] = y;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: hold the operation until a cycle with in_ready, then record the expectation
  task automatic send(input logic [2:0] op, input logic [127:0] a, input logic [127:0] b, input string tag);
    bit taken;
    taken = 1'b0;
    in_op = op; in_a = a; in_b = b; in_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      taken = in_ready;
      @(posedge clk); #1;
    end
    exp_q.push_back(ref_calc(op, a, b));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    in_valid = 1'b0;
  endtask

  // consumer throttle
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? (lfsr[0] | lfsr[5]) : rdy_manual;
  end

  // monitor: compare every result handed to the consumer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", out_data, '0);
      end else begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data === e, t, out_data, e);
      end
    end
  end

  function automatic logic [127:0] w4(logic [31:0] l0, logic [31:0] l1, logic [31:0] l2, logic [31:0] l3);
    return {l0, l1, l2, l3};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] pa, held;
    pa = 128'h80000001_12345678_FFFFFFFF_0F0F0F0F;

    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", {127'd0, out_valid}, '0);
    chk(in_ready == 1'b1, "R1", {127'd0, in_ready}, 128'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {126'd0, out_valid, in_ready}, 128'd1);
    @(posedge clk); #1;

    // R10: single operation, consumer always ready
    send(3'b000, pa, w4(32'd4, 32'd0, 32'd0, 32'd0), "R10");
    idle();
    @(negedge clk);
    chk(out_valid == 1'b1, "R10", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", {127'd0, out_valid}, '0);
    @(posedge clk); #1;

    // word modes, amounts at and around the lane width (back to back)
    send(3'b000, pa, w4(32'd0, 32'd4, 32'd31, 32'd32), "R2");
    send(3'b000, pa, w4(32'd63, 32'h41, 32'd33, 32'd1), "R2");
    send(3'b001, pa, w4(32'd0, 32'd4, 32'd31, 32'd32), "R3");
    send(3'b001, pa, w4(32'd63, 32'hFFFFFF41, 32'd33, 32'd1), "R3");
    send(3'b010, pa, w4(32'd0, 32'd4, 32'd31, 32'd32), "R4");
    send(3'b010, pa, w4(32'd63, 32'h41, 32'd33, 32'd1), "R4");
    // halfword modes
    send(3'b100, pa, 128'h0000_0001_000F_0010_001F_0025_0008_0003, "R5");
    send(3'b101, pa, 128'h0000_0001_000F_0010_001F_0025_0008_0003, "R5");
    send(3'b110, pa, 128'h0000_0001_000F_0010_001F_0025_0008_0003, "R6");
    // whole-vector rotates, amount from lane 0 of B
    send(3'b011, pa, w4(32'd0, 32'd9, 32'd9, 32'd9), "R7");
    send(3'b011, pa, w4(32'd1, 32'd0, 32'd0, 32'd0), "R7");
    send(3'b011, pa, w4(32'd64, 32'd0, 32'd0, 32'd0), "R7");
    send(3'b011, pa, w4(32'd127, 32'd0, 32'd0, 32'd0), "R7");
    send(3'b011, pa, w4(32'h85, 32'd0, 32'd0, 32'd0), "R7");
    send(3'b111, pa, w4(32'd0, 32'd0, 32'd0, 32'd0), "R8");
    send(3'b111, pa, w4(32'd1, 32'd0, 32'd0, 32'd0), "R8");
    send(3'b111, pa, w4(32'd15, 32'd0, 32'd0, 32'd0), "R8");
    send(3'b111, pa, w4(32'h13, 32'd7, 32'd7, 32'd7), "R8");
    // lane ordering: only one lane of B carries an amount
    send(3'b000, w4(32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444),
         w4(32'd8, 32'd0, 32'd0, 32'd0), "R9");
    send(3'b101, 128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_9999_8888,
         128'h0000_0000_0000_0000_0000_0000_0000_0004, "R9");
    idle();
    repeat (3) @(posedge clk); #1;

    // R11: stalled result is held and input is blocked
    rdy_manual = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    send(3'b010, rnd128(), rnd128(), "R11");
    in_op = 3'b001; in_a = rnd128(); in_b = rnd128();
    @(negedge clk);
    held = out_data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1 && out_data === held && in_ready == 1'b0, "R11", out_data, held);
    end
    idle();
    rdy_manual = 1'b1;
    repeat (3) @(posedge clk); #1;

    // random stream with a throttled consumer
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      string t;
      op = 3'($urandom);
      case (op)
        3'b000: t = "R2";
        3'b001: t = "R3";
        3'b010: t = "R4";
        3'b011: t = "R7";
        3'b110: t = "R6";
        3'b111: t = "R8";
        default: t = "R5";
      endcase
      send(op, rnd128(), rnd128(), t);
    end
    idle();
    bp_en = 1'b0;
    rdy_manual = 1'b1;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(posedge clk);
    chk(exp_q.size() == 0, "R11", 128'(exp_q.size()), '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule